// File: doc/BRIEF.md
# Overclock Watchdog with Safe Frequency Fallback

This block supervises the frequency-select code that drives a clock synthesizer's dividers. Once armed, it counts down a timeout measured in coarse units of a slow timebase tick. Software must service it before the count runs out, either with a kick strobe or by writing the enable bit. If the count runs out, the block takes three actions at once. It replaces the outgoing frequency code with a safe code that software programmed earlier. It latches an alarm status bit. It drives a long, fixed-width active-low system reset pulse for an open-drain reset line.

The timeout is an 8-bit unit count. Each unit is `UNIT_TICKS` timebase ticks, nominally one 290 ms step. The reset pulse lasts `PULSE_TICKS` ticks, nominally 288 ms. Both values are parameters, so a simulation can use small ones. The enable state after reset comes from a strap level sampled while reset is held. Software can later set or clear it. When no alarm is pending, the outgoing code is taken either from the strap pins or from a register field. A mode input picks the source, and mode 0 selects the pins.

Top module: `ocwdt_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `alarm_o` is 0 and `sysrst_n_o` is 1. `fs_o` carries `pin_fs_i` (pin source selected by mode 0).
- R2: The armed state is loaded from `en_strap_i` while `rst` is high. A cycle with `en_wr_i`=1 loads it from `en_val_i`. While disarmed, no number of ticks raises the alarm.
- R3: Once armed, the alarm rises on the clock edge of the timebase tick numbered `UNIT_TICKS*T` after the last reload, where T is `timeout_i` sampled at that reload. A T of 0 counts as one unit.
- R4: A reload happens on `kick_i` while armed, on an enable write with `en_val_i`=1, and on `alarm_clr_i`. A kick while disarmed has no effect.
- R5: `alarm_o` stays 1 until a cycle with `alarm_clr_i`=1, which returns it to 0 and restarts the timeout. While the alarm is set the countdown is frozen.
- R6: `safe_fs_i` is captured on the expiry edge. From the following cycle until the alarm clears, `fs_o` carries that captured code. Later changes to `safe_fs_i` have no effect.
- R7: `sysrst_n_o` falls on the same edge as `alarm_o` rises. It stays 0 for exactly `PULSE_TICKS` ticks and never falls at any other time. A pending alarm does not restart it.
- R8: With no alarm, `fs_o` is registered one cycle after its inputs. It follows `pin_fs_i` when `fs_mode_i`=0 and `reg_fs_i` when `fs_mode_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe of the slow timebase |
| en_strap_i | input | 1 | Armed level sampled during reset |
| en_wr_i | input | 1 | Write strobe for the armed bit |
| en_val_i | input | 1 | Value written to the armed bit (1 arms) |
| timeout_i | input | TMO_W | Timeout in units |
| safe_fs_i | input | FS_W | Fallback frequency code |
| kick_i | input | 1 | Service strobe |
| alarm_clr_i | input | 1 | Clears the alarm and restarts the timeout |
| fs_mode_i | input | 1 | 0 = pin code, 1 = register code |
| pin_fs_i | input | FS_W | Frequency code latched from pins |
| reg_fs_i | input | FS_W | Frequency code from register |
| fs_o | output | FS_W | Selected frequency code |
| alarm_o | output | 1 | Alarm status, 1 = expired |
| sysrst_n_o | output | 1 | Active-low reset pulse; 0 means pull low |

## Verification
The bench goes after the exact expiry tick. An off-by-one in the prescaler or unit counter shows up as an alarm one tick early or one unit late. A timeout of zero is also covered: a design that wraps the counter would wait 256 units instead of one. Kicks are given while disarmed and late in a countdown. A design that reloads on a disarmed kick, or ignores a live one, would expire at the wrong tick or not at all. The bench also runs long after expiry and changes the fallback input to catch a retriggered pulse or an unlatched safe code. It measures the pulse width tick by tick to catch a pulse one tick short or long.

// File: rtl/ocwdt_pkg.sv
package ocwdt_pkg;
  typedef enum logic {
    FS_SRC_PINS = 1'b0,
    FS_SRC_REG  = 1'b1
  } fs_src_e;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/ocwdt_prescale.sv
module ocwdt_prescale #(
  parameter int unsigned UNIT_TICKS = 290
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic unit_o
);
  localparam int unsigned PRE_W = ocwdt_pkg::cnt_width(UNIT_TICKS - 1);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(UNIT_TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             at_last;

  assign at_last = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      pre_q <= at_last ? '0 : pre_q + 1'b1;
    end
  end

  assign unit_o = run_i & ~restart_i & tick_i & at_last;
endmodule

// File: rtl/ocwdt_timer.sv
module ocwdt_timer #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             unit_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             last_unit;

  assign last_unit = (cnt_q <= TMO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || reload_i) begin
      cnt_q <= timeout_i;
    end else if (unit_i && !last_unit) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = unit_i & last_unit;
endmodule

// File: rtl/ocwdt_pulse.sv
module ocwdt_pulse #(
  parameter int unsigned PULSE_TICKS = 288
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic fire_i,
  output logic low_o
);
  localparam int unsigned PC_W = ocwdt_pkg::cnt_width(PULSE_TICKS);

  logic [PC_W-1:0] pc_q;
  logic            low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      low_q <= 1'b0;
    end else if (fire_i) begin
      pc_q  <= PC_W'(PULSE_TICKS);
      low_q <= 1'b1;
    end else if (tick_i && pc_q != '0) begin
      pc_q <= pc_q - 1'b1;
      if (pc_q == PC_W'(1)) low_q <= 1'b0;
    end
  end

  assign low_o = low_q;
endmodule

// File: rtl/ocwdt_fsel.sv
module ocwdt_fsel #(
  parameter int unsigned FS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            expire_i,
  input  logic            clr_i,
  input  logic [FS_W-1:0] safe_fs_i,
  input  logic            fs_mode_i,
  input  logic [FS_W-1:0] pin_fs_i,
  input  logic [FS_W-1:0] reg_fs_i,
  output logic            alarm_o,
  output logic [FS_W-1:0] safe_o,
  output logic [FS_W-1:0] fs_o
);
  import ocwdt_pkg::*;

  logic            alarm_q;
  logic [FS_W-1:0] safe_q;
  logic [FS_W-1:0] fs_q;
  logic [FS_W-1:0] norm_fs;

  always_comb begin
    case (fs_src_e'(fs_mode_i))
      FS_SRC_REG: norm_fs = reg_fs_i;
      default:    norm_fs = pin_fs_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
      safe_q  <= '0;
      fs_q    <= pin_fs_i;
    end else begin
      if (clr_i) alarm_q <= 1'b0;
      else if (expire_i) alarm_q <= 1'b1;
      if (expire_i) safe_q <= safe_fs_i;
      fs_q <= alarm_q ? safe_q : norm_fs;
    end
  end

  assign alarm_o = alarm_q;
  assign safe_o  = safe_q;
  assign fs_o    = fs_q;
endmodule

// File: rtl/ocwdt_top.sv
module ocwdt_top #(
  parameter int unsigned TMO_W       = 8,
  parameter int unsigned FS_W        = 4,
  parameter int unsigned UNIT_TICKS  = 290,
  parameter int unsigned PULSE_TICKS = 288
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_strap_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [FS_W-1:0]  safe_fs_i,
  input  logic             kick_i,
  input  logic             alarm_clr_i,
  input  logic             fs_mode_i,
  input  logic [FS_W-1:0]  pin_fs_i,
  input  logic [FS_W-1:0]  reg_fs_i,
  output logic [FS_W-1:0]  fs_o,
  output logic             alarm_o,
  output logic             sysrst_n_o
);
  logic            en_q;
  logic            run;
  logic            reload;
  logic            unit;
  logic            expire;
  logic            pulse_low;
  logic [FS_W-1:0] safe_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= en_strap_i;
    else if (en_wr_i) en_q <= en_val_i;
  end

  assign run    = en_q & ~alarm_o;
  assign reload = (kick_i & en_q) | (en_wr_i & en_val_i) | alarm_clr_i;

  ocwdt_prescale #(.UNIT_TICKS(UNIT_TICKS)) pre_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run),
    .restart_i(reload), .unit_o(unit)
  );

  ocwdt_timer #(.TMO_W(TMO_W)) tmr_i (
    .clk(clk), .rst(rst), .run_i(run), .reload_i(reload),
    .unit_i(unit), .timeout_i(timeout_i), .expire_o(expire)
  );

  ocwdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) pls_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .fire_i(expire), .low_o(pulse_low)
  );

  ocwdt_fsel #(.FS_W(FS_W)) sel_i (
    .clk(clk), .rst(rst), .expire_i(expire), .clr_i(alarm_clr_i),
    .safe_fs_i(safe_fs_i), .fs_mode_i(fs_mode_i), .pin_fs_i(pin_fs_i),
    .reg_fs_i(reg_fs_i), .alarm_o(alarm_o), .safe_o(safe_q), .fs_o(fs_o)
  );

  assign sysrst_n_o = ~pulse_low;
endmodule

// File: rtl/ocwdt_chk.sv
module ocwdt_chk #(
  parameter int unsigned FS_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_i,
  input logic            alarm_clr_i,
  input logic            en_q,
  input logic            alarm_o,
  input logic            sysrst_n_o,
  input logic [FS_W-1:0] fs_o,
  input logic [FS_W-1:0] safe_q
);
  p_pulse_on_alarm_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sysrst_n_o) |-> $rose(alarm_o));

  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sysrst_n_o) |-> $past(tick_i));

  p_alarm_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (alarm_o && !alarm_clr_i) |=> alarm_o);

  p_safe_code_r6: assert property (@(posedge clk) disable iff (rst)
    $past(alarm_o) |-> (fs_o == $past(safe_q)));

  p_disarmed_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !alarm_o) |=> !alarm_o);
endmodule

bind ocwdt_top ocwdt_chk #(.FS_W(FS_W)) chk_i (
  .clk(clk), .rst(rst), .tick_i(tick_i), .alarm_clr_i(alarm_clr_i),
  .en_q(en_q), .alarm_o(alarm_o), .sysrst_n_o(sysrst_n_o),
  .fs_o(fs_o), .safe_q(safe_q)
);

// File: tb/ocwdt_top_tb_top.sv
module ocwdt_top_tb_top;
  localparam int TMO_W = 8;
  localparam int FS_W  = 4;
  localparam int UNIT  = 4;
  localparam int PULSE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 0, en_strap_i = 0, en_wr_i = 0, en_val_i = 0;
  logic kick_i = 0, alarm_clr_i = 0, fs_mode_i = 0;
  logic [TMO_W-1:0] timeout_i = '0;
  logic [FS_W-1:0]  safe_fs_i = '0, pin_fs_i = 4'h5, reg_fs_i = '0;
  logic [FS_W-1:0]  fs_o;
  logic             alarm_o, sysrst_n_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ocwdt_top #(.TMO_W(TMO_W), .FS_W(FS_W), .UNIT_TICKS(UNIT), .PULSE_TICKS(PULSE)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .en_strap_i(en_strap_i),
    .en_wr_i(en_wr_i), .en_val_i(en_val_i), .timeout_i(timeout_i),
    .safe_fs_i(safe_fs_i), .kick_i(kick_i), .alarm_clr_i(alarm_clr_i),
    .fs_mode_i(fs_mode_i), .pin_fs_i(pin_fs_i), .reg_fs_i(reg_fs_i),
    .fs_o(fs_o), .alarm_o(alarm_o), .sysrst_n_o(sysrst_n_o)
  );

  function automatic int limit_of(input int t);
    return UNIT * ((t == 0) ? 1 : t);
  endfunction

  function automatic int norm_fs(input logic mode, input int pin, input int regv);
    return mode ? regv : pin;
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic kick();
    kick_i = 1'b1; @(negedge clk); kick_i = 1'b0;
  endtask

  task automatic clr();
    alarm_clr_i = 1'b1; @(negedge clk); alarm_clr_i = 1'b0;
  endtask

  task automatic en_write(input logic v);
    en_wr_i = 1'b1; en_val_i = v; @(negedge clk); en_wr_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got 0 expected 1 (run hung)");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(alarm_o, 0, "R1 alarm");
    chk(sysrst_n_o, 1, "R1 sysrst_n");
    chk(fs_o, 5, "R1 fs pins");

    // R2 strap 0 keeps it disarmed; R4 kicks while disarmed do nothing
    ticks(20);
    kick(); ticks(10); kick();
    ticks(20);
    chk(alarm_o, 0, "R2/R4 disarmed no alarm");
    chk(sysrst_n_o, 1, "R4 disarmed no pulse");

    // R3 exact expiry with T=3
    timeout_i = 8'd3; safe_fs_i = 4'hA;
    en_write(1'b1);
    ticks(limit_of(3) - 1);
    chk(alarm_o, 0, "R3 one tick before expiry");
    ticks(1);
    chk(alarm_o, 1, "R3/R5 alarm at expiry");
    chk(sysrst_n_o, 0, "R7 pulse starts with alarm");
    cyc(1);
    chk(fs_o, 10, "R6 safe code out");
    safe_fs_i = 4'h2;
    ticks(PULSE - 1);
    chk(sysrst_n_o, 0, "R7 pulse still low");
    ticks(1);
    chk(sysrst_n_o, 1, "R7 pulse released at width");
    ticks(30);
    chk(alarm_o, 1, "R5 alarm held");
    chk(sysrst_n_o, 1, "R7 no retrigger");
    chk(fs_o, 10, "R6 captured code kept");

    // R5 clear, R8 source select
    clr();
    chk(alarm_o, 0, "R5 clear");
    cyc(1);
    chk(fs_o, 5, "R8 pin source");
    fs_mode_i = 1'b1; reg_fs_i = 4'h3;
    cyc(1);
    chk(fs_o, 3, "R8 register source");

    // R3 timeout of zero means one unit
    timeout_i = 8'd0;
    clr();
    ticks(UNIT - 1);
    chk(alarm_o, 0, "R3 T0 before");
    ticks(1);
    chk(alarm_o, 1, "R3 T0 expiry");
    ticks(PULSE);

    // R4 live kick restarts the count
    timeout_i = 8'd2;
    clr();
    ticks(6);
    kick();
    ticks(limit_of(2) - 1);
    chk(alarm_o, 0, "R4 kick delayed expiry");
    ticks(1);
    chk(alarm_o, 1, "R4 expiry after kick");
    ticks(PULSE);

    // R2 software disarm
    clr();
    en_write(1'b0);
    ticks(40);
    chk(alarm_o, 0, "R2 disarmed by write");
    en_write(1'b1);

    // random runs
    for (int it = 0; it < 24; it++) begin
      int t, lim, n, pin, regv, safe;
      logic mode;
      t    = $urandom_range(0, 5);
      lim  = limit_of(t);
      pin  = $urandom_range(0, 15);
      regv = $urandom_range(0, 15);
      safe = $urandom_range(0, 15);
      mode = 1'($urandom_range(0, 1));
      timeout_i = TMO_W'(t); pin_fs_i = FS_W'(pin); reg_fs_i = FS_W'(regv);
      fs_mode_i = mode; safe_fs_i = FS_W'(safe);
      clr();
      cyc(1);
      chk(fs_o, norm_fs(mode, pin, regv), "R8 random select");
      n = $urandom_range(0, lim - 1);
      ticks(n);
      if ($urandom_range(0, 1) == 1) begin
        kick();
        ticks(lim - 1);
      end else begin
        ticks(lim - 1 - n);
      end
      chk(alarm_o, 0, "R3 random before");
      ticks(1);
      chk(alarm_o, 1, "R3 random expiry");
      chk(sysrst_n_o, 0, "R7 random pulse");
      safe_fs_i = ~safe_fs_i;
      cyc(1);
      chk(fs_o, safe, "R6 random safe");
      ticks(PULSE);
      chk(sysrst_n_o, 1, "R7 random release");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule